// File: doc/BRIEF.md
# Set-Clear-Toggle Control Register Bank

This block is a bank of 32-bit control registers on a single-beat synchronous register bus. Each register occupies a 16-byte slot and can be reached through four aliases in that slot. The plain alias replaces the register with the write data. The other three change only the bits that are one in the write data: they set those bits, clear them, or invert them. Software can therefore update a single control bit without a read-modify-write sequence, and without racing other agents that own other bits of the same register.

Every alias of a slot reads back the same register. Each register takes a reset value from a parameter table. Registers marked as clock-synthesizer controls also come out of reset with their lock status bit set. A read-only identification word sits at a fixed address, and it wins over the bank wherever the two overlap. Read data is registered and appears one cycle after the read strobe. Accesses that are not word-aligned, and accesses to slots beyond the implemented count, are dropped.

Top module: `sct_regbank`

## Requirements
- R1: Address bits [3:2] select the write operation (bits [1:0] are zero): 0x0 replaces the register with the data, 0x4 ORs the data in, 0x8 clears every bit that is one in the data, and 0xC XORs the data in.
- R2: The register index is address bits [ADDR_W-1:4], so each register owns a 16-byte slot that holds its four aliases.
- R3: A read at any of the four aliases returns the same register. Read data appears on rd_data in the cycle after rd_en and holds while rd_en is low.
- R4: An access whose address bits [1:0] are not zero is dropped. A write has no effect, and a read returns zero.
- R5: On reset, each register loads its entry from RST_VALS (register 0 in the low 32 bits). With the defaults, register 0 is 0x00002042, register 1 is 0x0060302C, register 3 is 0x00001FC0, and all others are zero before R6 applies.
- R6: Registers flagged in PLL_MASK (by default 0, 1 and 3) also have bit LOCK_BIT (31) set at reset. Their reset reads are therefore 0x80002042, 0x8060302C and 0x80001FC0.
- R7: The address ID_ADDR (0x070) reads ID_VALUE (0x00720010) instead of the bank register there, and writes to it are ignored. The other three aliases in that slot (0x074, 0x078, 0x07C) still reach register 7.
- R8: A slot index of NUM_REGS or more is out of range. Writes to it are dropped, and reads from it return zero.
- R9: A write changes the register at the clock edge that accepts it. A read issued in the same cycle returns the old value, and a read in the next cycle returns the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address of the access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Write data or bit mask |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DATA_W | Registered read data |

## Verification
A read and a write can fall in the same cycle, even on the same register through different aliases. In that case the read must return the value from before the write, and a read one cycle later must show the change. The bench provokes this with directed same-cycle set and toggle accesses on one register. It judges the result against a shadow model that is updated only after the read expectation is taken. Random sequences over every alias, including out-of-range slots and the identification address, then check that the model and the bank stay in step.

// File: rtl/sct_pkg.sv
package sct_pkg;
  typedef enum logic [1:0] {
    OP_WRITE  = 2'b00,
    OP_SET    = 2'b01,
    OP_CLEAR  = 2'b10,
    OP_TOGGLE = 2'b11
  } sct_op_e;
endpackage

// File: rtl/sct_decode.sv
module sct_decode #(
  parameter int ADDR_W   = 12,
  parameter int NUM_REGS = 8,
  parameter logic [ADDR_W-1:0] ID_ADDR = 12'h070,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic [ADDR_W-1:0] addr,
  output sct_pkg::sct_op_e  op,
  output logic [IDX_W-1:0]  idx,
  output logic              aligned,
  output logic              in_range,
  output logic              id_hit
);
  localparam int SLOT_W = ADDR_W - 4;
  localparam logic [SLOT_W:0] LIMIT = (SLOT_W+1)'(NUM_REGS);

  logic [SLOT_W-1:0] slot;

  always_comb begin
    slot     = addr[ADDR_W-1:4];
    op       = sct_pkg::sct_op_e'(addr[3:2]);
    idx      = slot[IDX_W-1:0];
    aligned  = (addr[1:0] == 2'b00);
    in_range = ({1'b0, slot} < LIMIT);
    id_hit   = (addr == ID_ADDR);
  end
endmodule

// File: rtl/sct_bitop.sv
module sct_bitop #(
  parameter int DATA_W = 32
) (
  input  sct_pkg::sct_op_e  op,
  input  logic [DATA_W-1:0] cur,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] nxt
);
  always_comb begin
    unique case (op)
      sct_pkg::OP_WRITE:  nxt = data;
      sct_pkg::OP_SET:    nxt = cur | data;
      sct_pkg::OP_CLEAR:  nxt = cur & ~data;
      sct_pkg::OP_TOGGLE: nxt = cur ^ data;
      default:            nxt = cur;
    endcase
  end
endmodule

// File: rtl/sct_reg_cell.sv
module sct_reg_cell #(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= RST_VAL;
    else if (we) q <= d;
  end
endmodule

// File: rtl/sct_regbank.sv
module sct_regbank #(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  parameter logic [NUM_REGS*DATA_W-1:0] RST_VALS = {
    32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000,
    32'h0000_1fc0, 32'h0000_0000, 32'h0060_302c, 32'h0000_2042},
  parameter logic [NUM_REGS-1:0] PLL_MASK = 8'b0000_1011,
  parameter int LOCK_BIT = 31,
  parameter logic [ADDR_W-1:0] ID_ADDR  = 12'h070,
  parameter logic [DATA_W-1:0] ID_VALUE = 32'h0072_0010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data
);
  localparam int IDX_W = $clog2(NUM_REGS);
  localparam logic [DATA_W-1:0] LOCK_MSK = DATA_W'(1) << LOCK_BIT;

  sct_pkg::sct_op_e op;
  logic [IDX_W-1:0] idx;
  logic aligned, in_range, id_hit, wr_ok;
  logic [DATA_W-1:0] cur, nxt, rd_next;
  logic [DATA_W-1:0] regs [NUM_REGS];
  logic [NUM_REGS*DATA_W-1:0] regs_flat;

  sct_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .ID_ADDR(ID_ADDR)) u_dec (
    .addr(addr), .op(op), .idx(idx), .aligned(aligned),
    .in_range(in_range), .id_hit(id_hit));

  assign cur   = regs[idx];
  assign wr_ok = wr_en && aligned && in_range && !id_hit;

  sct_bitop #(.DATA_W(DATA_W)) u_op (.op(op), .cur(cur), .data(wr_data), .nxt(nxt));

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [DATA_W-1:0] RV =
      RST_VALS[i*DATA_W +: DATA_W] | (PLL_MASK[i] ? LOCK_MSK : '0);
    sct_reg_cell #(.DATA_W(DATA_W), .RST_VAL(RV)) u_cell (
      .clk(clk), .rst(rst), .we(wr_ok && (idx == IDX_W'(i))),
      .d(nxt), .q(regs[i]));
    assign regs_flat[i*DATA_W +: DATA_W] = regs[i];
  end

  always_comb begin
    if (!aligned)      rd_next = '0;
    else if (id_hit)   rd_next = ID_VALUE;
    else if (in_range) rd_next = cur;
    else               rd_next = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end
endmodule

// File: rtl/sct_regbank_chk.sv
module sct_regbank_chk #(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  parameter logic [ADDR_W-1:0] ID_ADDR  = 12'h070,
  parameter logic [DATA_W-1:0] ID_VALUE = 32'h0072_0010
) (
  input logic clk,
  input logic rst,
  input logic [ADDR_W-1:0] addr,
  input logic wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic [NUM_REGS*DATA_W-1:0] regs_flat
);
  localparam int IDX_W = $clog2(NUM_REGS);
  logic [ADDR_W-5:0] slot;
  logic [IDX_W-1:0] ix;
  logic ok_w;
  assign slot = addr[ADDR_W-1:4];
  assign ix   = slot[IDX_W-1:0];
  assign ok_w = wr_en && addr[1:0] == 2'b00 && 32'(slot) < NUM_REGS && addr != ID_ADDR;

  p_id_read_r7: assert property (@(posedge clk) disable iff (rst)
    rd_en && addr == ID_ADDR |=> rd_data == ID_VALUE);
  p_rd_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
  p_unaligned_zero_r4: assert property (@(posedge clk) disable iff (rst)
    rd_en && addr[1:0] != 2'b00 |=> rd_data == '0);
  p_oob_zero_r8: assert property (@(posedge clk) disable iff (rst)
    rd_en && addr[1:0] == 2'b00 && 32'(slot) >= NUM_REGS && addr != ID_ADDR |=> rd_data == '0);
  p_set_bits_r1: assert property (@(posedge clk) disable iff (rst)
    ok_w && addr[3:2] == 2'b01 |=>
      (regs_flat[$past(ix)*DATA_W +: DATA_W] & $past(wr_data)) == $past(wr_data));
  p_clear_bits_r1: assert property (@(posedge clk) disable iff (rst)
    ok_w && addr[3:2] == 2'b10 |=>
      (regs_flat[$past(ix)*DATA_W +: DATA_W] & $past(wr_data)) == '0);
endmodule

bind sct_regbank sct_regbank_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS),
  .ID_ADDR(ID_ADDR), .ID_VALUE(ID_VALUE)
) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .rd_en(rd_en), .rd_data(rd_data), .regs_flat(regs_flat)
);

// File: tb/sct_regbank_test.sv
`timescale 1ns/1ps
module sct_regbank_test;
  localparam int N = 8;
  localparam logic [11:0] IDA = 12'h070;
  localparam logic [31:0] IDV = 32'h0072_0010;

  logic clk = 0, rst = 1, wr_en = 0, rd_en = 0;
  logic [11:0] addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  int checks = 0, errors = 0;
  logic [31:0] m [N];

  always #10 clk = ~clk;

  sct_regbank uut (.clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] apply(input logic [1:0] op, input logic [31:0] c, input logic [31:0] d);
    case (op)
      2'd0: return d;
      2'd1: return c | d;
      2'd2: return c & ~d;
      default: return c ^ d;
    endcase
  endfunction

  function automatic logic [31:0] expect_rd(input logic [11:0] a);
    if (a[1:0] != 0) return 0;
    if (a == IDA) return IDV;
    if (a[11:4] < N) return m[a[6:4]];
    return 0;
  endfunction

  function automatic void model_wr(input logic [11:0] a, input logic [31:0] d);
    if (a[1:0] == 0 && a != IDA && a[11:4] < N)
      m[a[6:4]] = apply(a[3:2], m[a[6:4]], d);
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1;
    @(posedge clk); #1; wr_en = 0;
    model_wr(a, d);
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] r);
    @(negedge clk); addr = a; rd_en = 1;
    @(posedge clk); #1; rd_en = 0; r = rd_data;
  endtask

  initial begin
    #(20ns * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd20240611));
    m[0] = 32'h8000_2042; m[1] = 32'h8060_302c; m[2] = 0; m[3] = 32'h8000_1fc0;
    for (int i = 4; i < N; i++) m[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1 chk("R3 rd_data reset", rd_data, 32'h0);
    // R5 / R6 reset values with lock bit
    for (int i = 0; i < N; i++) begin
      rd({4'h0, 4'(i), 4'h0} | (i == 7 ? 12'h004 : 12'h000), r);
      chk((i == 0 || i == 1 || i == 3) ? "R6 lock reset" : "R5 reset value", r, m[i]);
    end
    // R1 each op, R2 stride, R3 alias reads
    wr(12'h020, 32'hF0F0_1234); rd(12'h020, r); chk("R1 write", r, 32'hF0F0_1234);
    wr(12'h024, 32'h0000_00FF); rd(12'h028, r); chk("R1 set", r, 32'hF0F0_12FF);
    wr(12'h028, 32'hF000_000F); rd(12'h02C, r); chk("R1 clear", r, 32'h00F0_12F0);
    wr(12'h02C, 32'hFFFF_0000); rd(12'h024, r); chk("R1 toggle", r, 32'hFF0F_12F0);
    rd(12'h030, r); chk("R2 neighbour slot untouched", r, m[3]);
    // R4 unaligned
    wr(12'h021, 32'h0); rd(12'h020, r); chk("R4 unaligned write dropped", r, 32'hFF0F_12F0);
    rd(12'h022, r); chk("R4 unaligned read zero", r, 32'h0);
    // R7 identification word
    wr(IDA, 32'hDEAD_BEEF); rd(IDA, r); chk("R7 id read", r, IDV);
    wr(12'h074, 32'h0000_0A00); rd(12'h078, r); chk("R7 slot aliases reach reg7", r, 32'h0000_0A00);
    rd(IDA, r); chk("R7 id unchanged", r, IDV);
    // R8 out of range
    wr(12'h084, 32'hFFFF_FFFF); rd(12'h080, r); chk("R8 oob read zero", r, 32'h0);
    for (int i = 0; i < N; i++) begin
      rd({4'h0, 4'(i), 4'h4}, r); chk("R8 bank untouched", r, m[i]);
    end
    // R9 same-cycle read and write
    @(negedge clk); addr = 12'h014; wr_data = 32'h0000_0F00; wr_en = 1; rd_en = 1;
    @(posedge clk); #1; wr_en = 0; rd_en = 0;
    chk("R9 same-cycle read old", rd_data, m[1]);
    model_wr(12'h014, 32'h0000_0F00);
    rd(12'h010, r); chk("R9 next read new", r, m[1]);
    @(negedge clk); addr = 12'h01C; wr_data = 32'h8000_0001; wr_en = 1; rd_en = 1;
    @(posedge clk); #1; wr_en = 0; rd_en = 0;
    chk("R9 same-cycle toggle old", rd_data, m[1]);
    model_wr(12'h01C, 32'h8000_0001);
    // R3 hold while rd_en low
    repeat (2) @(posedge clk); #1 chk("R3 hold", rd_data, m[1] ^ 32'h8000_0001);
    rd(12'h018, r); chk("R9 toggle visible", r, m[1]);
    // random mix R1 R2 R3 R7 R8
    for (int k = 0; k < 400; k++) begin
      logic [11:0] a;
      a = {4'h0, 4'($urandom % 10), 2'($urandom), 2'b00};
      if ($urandom % 2) wr(a, $urandom);
      else begin
        logic [31:0] e;
        e = expect_rd(a);
        rd(a, r); chk("R1 random shadow compare", r, e);
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule